// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recently used page-table entries so that a 32-bit virtual address with 4 KB pages can be turned into a physical address without walking the tables in memory. A lookup takes the virtual address and, in the same cycle, reports whether the leaf entry for its 20-bit page number is held. On a hit it also reports the physical address, which is the cached frame number joined to the unchanged 12-bit offset. In the same cycle it separately reports whether the directory-level entry covering that address is held. When the leaf is absent, the block raises a miss. The external table walker then fetches what is missing and writes it back through the refill port. A cached directory entry lets the walker skip the first memory read.

Storage is 16 sets of 4 ways, and the two entry kinds share it. A flag in each way marks it as directory-level (1) or leaf (0). Replacement within a set prefers an empty way. When no way is empty, a 3-bit tree pseudo-LRU picks the victim. Two flush inputs clear the structure for a task switch. One clears everything. The other spares entries whose cached global bit is set.

The write path is decoded each cycle into one of four actions, with flushes taking priority: WR_IDLE (no change), WR_FLUSH_ALL, WR_FLUSH_TASK and WR_FILL. Every action lasts one cycle and returns to WR_IDLE unless the inputs hold it.

Top module: `tlb_cache`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every way is empty and every replacement tree is zero, so no lookup hits until a refill.
- R2: A leaf lookup uses page-number bits [3:0] as the set and bits [19:4] as the tag. It hits only on a valid way whose flag is 0 and whose tag is equal. A directory entry never produces a leaf hit.
- R3: While lk_en is high and the leaf hits, lk_pa equals {lk_pte[31:12], lk_va[11:0]} and lk_pte equals the cached entry, both in the same cycle. Without a leaf hit, lk_pa and lk_pte are zero.
- R4: lk_miss is high exactly when lk_en is high and there is no leaf hit. With lk_en low, lk_hit, lk_miss and lk_dir_hit are all low.
- R5: A directory lookup uses page-number bits [13:10] as the set. It compares the stored tag with page-number bits [19:10] zero-extended to 16 bits, and needs the flag to be 1. On a hit, lk_dir_pte returns the entry; otherwise lk_dir_pte is zero.
- R6: With fill_en high, the entry is written at the clock edge into the set and tag that R2 (fill_dir=0) or R5 (fill_dir=1) gives for fill_vpn. It is visible to lookups from the next cycle and not in the cycle of the write.
- R7: A refill whose set, tag and flag already match a valid way overwrites that way, so no two valid ways in a set ever match the same lookup.
- R8: Without such a match, a refill goes to the lowest-numbered empty way of the set. With the set full, it goes to the pseudo-LRU victim.
- R9: The tree has root bit 0 (0 = left half ways 0-1, 1 = right half ways 2-3), bit 1 choosing way 0 (0) or way 1 (1), and bit 2 choosing way 2 (0) or way 3 (1). A refill or hit on a way sets the bits on its path to point away from it. In one cycle, a refill update wins over a leaf hit, and a leaf hit wins over a directory hit in the same set.
- R10: flush_all clears every valid bit in one cycle, so no lookup hits in the next cycle.
- R11: flush_task clears only ways whose cached entry has bit 8 (global) equal to 0. Global entries keep hitting.
- R12: A refill in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Leaf entry held for lk_va |
| lk_miss | output | 1 | Lookup requested, leaf entry absent |
| lk_pa | output | 32 | Physical address on a leaf hit, else zero |
| lk_pte | output | 32 | Cached leaf entry on a hit, else zero |
| lk_dir_hit | output | 1 | Directory entry held for lk_va |
| lk_dir_pte | output | 32 | Cached directory entry on a hit, else zero |
| fill_en | input | 1 | Refill write |
| fill_dir | input | 1 | Refill kind: 1 directory, 0 leaf |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pte | input | 32 | Table entry to store |
| flush_all | input | 1 | Invalidate every entry |
| flush_task | input | 1 | Invalidate non-global entries |

## Verification
The assertions check several properties on every clocked cycle. No set ever holds two valid ways that match the same lookup. A refill that finds an empty way in its set uses one. A touched way is never the next victim of its set. A refill is visible in the following cycle. No entry survives flush_all. A flush_task spares a global leaf and removes a non-global one. Only the bench scenarios can show the exact eviction order of the tree after a series of fills and hits. They also show that a refill overwrites its own way instead of evicting a neighbour, that the directory flag keeps the two entry kinds apart when a set and tag collide, and that the physical addresses and entries returned carry the expected values.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int VPN_W     = 20;
    localparam int OFF_W     = 12;
    localparam int PTE_W     = 32;
    localparam int GLB_BIT   = 8;
    localparam int DIR_W     = 10;
    localparam int SET_BITS  = 4;
    localparam int WAYS      = 4;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_FLUSH_ALL,
        WR_FLUSH_TASK,
        WR_FILL
    } wr_op_e;
endpackage

// File: rtl/tlb_probe.sv
`timescale 1ns/1ps
module tlb_probe #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int PTE_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             row_valid,
    input  logic [WAYS-1:0]             row_dir,
    input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
    input  logic [WAYS-1:0][PTE_W-1:0]  row_pte,
    input  logic                        want_dir,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_way,
    output logic [PTE_W-1:0]            hit_pte
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] match;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match[w] = row_valid[w] && (row_dir[w] == want_dir) && (row_tag[w] == key);
        end
    end

    always_comb begin
        hit_way = '0;
        hit_pte = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
                hit_pte = row_pte[w];
            end
        end
    end

    assign hit = |match;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)) else $error("duplicate match in set"); // R7
endmodule

// File: rtl/tlb_plru.sv
`timescale 1ns/1ps
module tlb_plru #(
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int LG    = $clog2(WAYS);
    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] tree_q;
    logic [NODES-1:0] tree_d;
    int               walk;
    int               climb;
    int               parent;

    always_comb begin
        walk = 0;
        for (int l = 0; l < LG; l++) begin
            walk = 2 * walk + 1 + int'(tree_q[walk]);
        end
        victim = LG'(walk - NODES);
    end

    always_comb begin
        tree_d = tree_q;
        climb  = int'(touch_way) + NODES;
        parent = 0;
        for (int l = 0; l < LG; l++) begin
            parent         = (climb - 1) / 2;
            tree_d[parent] = (climb == 2 * parent + 1);
            climb          = parent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tree_q <= '0;
        end else if (touch_en) begin
            tree_q <= tree_d;
        end
    end

    AST_PLRU_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (victim != $past(touch_way))) else $error("victim is last touched way"); // R9
endmodule

// File: rtl/tlb_pick.sv
`timescale 1ns/1ps
module tlb_pick #(
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit,
    input  logic [$clog2(WAYS)-1:0] hit_way,
    input  logic [WAYS-1:0]         row_valid,
    input  logic [$clog2(WAYS)-1:0] plru_way,
    output logic [$clog2(WAYS)-1:0] pick
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] free_way;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!row_valid[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        if (hit) begin
            pick = hit_way;
        end else if (!(&row_valid)) begin
            pick = free_way;
        end else begin
            pick = plru_way;
        end
    end

    AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !(&row_valid)) |-> !row_valid[pick]) else $error("valid way chosen over free way"); // R8
endmodule

// File: rtl/tlb_cache.sv
`timescale 1ns/1ps
module tlb_cache #(
    parameter int SET_BITS = tlb_pkg::SET_BITS,
    parameter int WAYS     = tlb_pkg::WAYS,
    parameter int DIR_W    = tlb_pkg::DIR_W,
    parameter int VPN_W    = tlb_pkg::VPN_W,
    parameter int OFF_W    = tlb_pkg::OFF_W,
    parameter int PTE_W    = tlb_pkg::PTE_W,
    parameter int GLB_BIT  = tlb_pkg::GLB_BIT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_en,
    input  logic [VPN_W+OFF_W-1:0] lk_va,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PTE_W-1:0]       lk_pa,
    output logic [PTE_W-1:0]       lk_pte,
    output logic                   lk_dir_hit,
    output logic [PTE_W-1:0]       lk_dir_pte,
    input  logic                   fill_en,
    input  logic                   fill_dir,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PTE_W-1:0]       fill_pte,
    input  logic                   flush_all,
    input  logic                   flush_task
);
    import tlb_pkg::*;

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = VPN_W - SET_BITS;
    localparam int WAY_W = $clog2(WAYS);
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PPN_W = PTE_W - OFF_W;
    localparam int PAD_W = TAG_W - DIR_W;

    // storage
    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0]             dir_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][PTE_W-1:0]  pte_q;

    // address split
    logic [VPN_W-1:0]    lk_vpn;
    logic [SET_BITS-1:0] leaf_set;
    logic [TAG_W-1:0]    leaf_key;
    logic [SET_BITS-1:0] dir_set;
    logic [TAG_W-1:0]    dir_key;
    logic [SET_BITS-1:0] fill_set;
    logic [TAG_W-1:0]    fill_key;

    assign lk_vpn   = lk_va[VA_W-1:OFF_W];
    assign leaf_set = lk_vpn[SET_BITS-1:0];
    assign leaf_key = lk_vpn[VPN_W-1:SET_BITS];
    assign dir_set  = lk_vpn[VPN_W-DIR_W +: SET_BITS];
    assign dir_key  = {{PAD_W{1'b0}}, lk_vpn[VPN_W-1 -: DIR_W]};

    always_comb begin
        if (fill_dir) begin
            fill_set = fill_vpn[VPN_W-DIR_W +: SET_BITS];
            fill_key = {{PAD_W{1'b0}}, fill_vpn[VPN_W-1 -: DIR_W]};
        end else begin
            fill_set = fill_vpn[SET_BITS-1:0];
            fill_key = fill_vpn[VPN_W-1:SET_BITS];
        end
    end

    // probes
    logic             leaf_raw, dir_raw, fill_raw;
    logic [WAY_W-1:0] leaf_way, dir_way, fill_match_way, fill_way;
    logic [PTE_W-1:0] leaf_pte, dir_pte, fill_old_pte;

    tlb_probe #(.WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_probe_leaf (
        .clk(clk), .rst_n(rst_n),
        .row_valid(valid_q[leaf_set]), .row_dir(dir_q[leaf_set]),
        .row_tag(tag_q[leaf_set]), .row_pte(pte_q[leaf_set]),
        .want_dir(1'b0), .key(leaf_key),
        .hit(leaf_raw), .hit_way(leaf_way), .hit_pte(leaf_pte)
    );

    tlb_probe #(.WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_probe_dir (
        .clk(clk), .rst_n(rst_n),
        .row_valid(valid_q[dir_set]), .row_dir(dir_q[dir_set]),
        .row_tag(tag_q[dir_set]), .row_pte(pte_q[dir_set]),
        .want_dir(1'b1), .key(dir_key),
        .hit(dir_raw), .hit_way(dir_way), .hit_pte(dir_pte)
    );

    tlb_probe #(.WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_probe_fill (
        .clk(clk), .rst_n(rst_n),
        .row_valid(valid_q[fill_set]), .row_dir(dir_q[fill_set]),
        .row_tag(tag_q[fill_set]), .row_pte(pte_q[fill_set]),
        .want_dir(fill_dir), .key(fill_key),
        .hit(fill_raw), .hit_way(fill_match_way), .hit_pte(fill_old_pte)
    );

    // lookup outputs
    always_comb begin
        lk_hit     = lk_en && leaf_raw;
        lk_miss    = lk_en && !leaf_raw;
        lk_dir_hit = lk_en && dir_raw;
        lk_pte     = lk_hit ? leaf_pte : '0;
        lk_pa      = lk_hit ? {leaf_pte[PTE_W-1 -: PPN_W], lk_va[OFF_W-1:0]} : '0;
        lk_dir_pte = lk_dir_hit ? dir_pte : '0;
    end

    // write action decode
    wr_op_e wr_op;

    always_comb begin
        if (flush_all) begin
            wr_op = WR_FLUSH_ALL;
        end else if (flush_task) begin
            wr_op = WR_FLUSH_TASK;
        end else if (fill_en) begin
            wr_op = WR_FILL;
        end else begin
            wr_op = WR_IDLE;
        end
    end

    // replacement state, one tree per set
    logic [SETS-1:0]            touch_en;
    logic [SETS-1:0][WAY_W-1:0] touch_way;
    logic [SETS-1:0][WAY_W-1:0] set_victim;

    genvar gs;
    generate
        for (gs = 0; gs < SETS; gs++) begin : g_set
            always_comb begin
                touch_en[gs]  = 1'b0;
                touch_way[gs] = '0;
                if (wr_op == WR_FILL && fill_set == SET_BITS'(gs)) begin
                    touch_en[gs]  = 1'b1;
                    touch_way[gs] = fill_way;
                end else if (lk_hit && leaf_set == SET_BITS'(gs)) begin
                    touch_en[gs]  = 1'b1;
                    touch_way[gs] = leaf_way;
                end else if (lk_dir_hit && dir_set == SET_BITS'(gs)) begin
                    touch_en[gs]  = 1'b1;
                    touch_way[gs] = dir_way;
                end
            end

            tlb_plru #(.WAYS(WAYS)) u_plru (
                .clk(clk), .rst_n(rst_n),
                .touch_en(touch_en[gs]), .touch_way(touch_way[gs]),
                .victim(set_victim[gs])
            );
        end
    endgenerate

    tlb_pick #(.WAYS(WAYS)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .hit(fill_raw), .hit_way(fill_match_way),
        .row_valid(valid_q[fill_set]), .plru_way(set_victim[fill_set]),
        .pick(fill_way)
    );

    // storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dir_q   <= '0;
            tag_q   <= '0;
            pte_q   <= '0;
        end else begin
            unique case (wr_op)
                WR_FLUSH_ALL: begin
                    valid_q <= '0;
                end
                WR_FLUSH_TASK: begin
                    for (int s = 0; s < SETS; s++) begin
                        for (int w = 0; w < WAYS; w++) begin
                            if (!pte_q[s][w][GLB_BIT]) begin
                                valid_q[s][w] <= 1'b0;
                            end
                        end
                    end
                end
                WR_FILL: begin
                    valid_q[fill_set][fill_way] <= 1'b1;
                    dir_q[fill_set][fill_way]   <= fill_dir;
                    tag_q[fill_set][fill_way]   <= fill_key;
                    pte_q[fill_set][fill_way]   <= fill_pte;
                end
                WR_IDLE: begin
                end
            endcase
        end
    end

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (!lk_hit && !lk_dir_hit)) else $error("hit after full flush"); // R10

    AST_FILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_dir && !flush_all && !flush_task)
        |=> ((lk_en && lk_va[VA_W-1:OFF_W] == $past(fill_vpn)) -> lk_hit)) else $error("refill not visible"); // R6

    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_task && !flush_all && lk_hit && lk_pte[GLB_BIT])
        |=> ((lk_en && lk_va[VA_W-1:OFF_W] == $past(lk_va[VA_W-1:OFF_W])) -> lk_hit)) else $error("global entry lost"); // R11

    AST_LOCAL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_task && !flush_all && lk_hit && !lk_pte[GLB_BIT])
        |=> ((lk_en && lk_va[VA_W-1:OFF_W] == $past(lk_va[VA_W-1:OFF_W])) -> !lk_hit)) else $error("local entry kept"); // R11
endmodule

// File: tb/tlb_cache_bench.sv
`timescale 1ns/1ps
module tlb_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_en;
    logic [31:0] lk_va;
    logic        lk_hit, lk_miss, lk_dir_hit;
    logic [31:0] lk_pa, lk_pte, lk_dir_pte;
    logic        fill_en, fill_dir;
    logic [19:0] fill_vpn;
    logic [31:0] fill_pte;
    logic        flush_all, flush_task;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    tlb_cache u_tlb_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_en(lk_en), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_pte(lk_pte),
        .lk_dir_hit(lk_dir_hit), .lk_dir_pte(lk_dir_pte),
        .fill_en(fill_en), .fill_dir(fill_dir), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .flush_all(flush_all), .flush_task(flush_task)
    );

    typedef enum logic [2:0] {OP_LOOK, OP_FILL_L, OP_FILL_D, OP_FLUSH_TASK, OP_FLUSH_ALL} op_e;

    typedef struct packed {
        op_e         op;
        logic [31:0] va;
        logic [31:0] data;
        logic        exp_lh;
        logic        exp_dh;
        logic [31:0] exp_pte;
        logic [31:0] exp_pde;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    // exp_pte is the expected leaf entry; the expected physical address is derived from it
    localparam vec_t VECS [NV] = '{
        '{OP_LOOK,       32'h00010123, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd1},  // R1 empty after reset
        '{OP_FILL_L,     32'h00010000, 32'h11111001, 1'b0, 1'b0, 32'h0,        32'h0,        8'd6},
        '{OP_LOOK,       32'h00010ABC, 32'h0,        1'b1, 1'b0, 32'h11111001, 32'h0,        8'd3},  // R3 pa build
        '{OP_FILL_L,     32'h00020000, 32'h22222101, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},
        '{OP_FILL_L,     32'h00030000, 32'h33333001, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},
        '{OP_FILL_L,     32'h00040000, 32'h44444001, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},
        '{OP_FILL_L,     32'h00050000, 32'h55555001, 1'b0, 1'b0, 32'h0,        32'h0,        8'd8},
        '{OP_LOOK,       32'h00010000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd8},  // R8 way 0 evicted
        '{OP_LOOK,       32'h00020FFF, 32'h0,        1'b1, 1'b0, 32'h22222101, 32'h0,        8'd9},  // R9 touch way 1
        '{OP_FILL_L,     32'h00060000, 32'h66666001, 1'b0, 1'b0, 32'h0,        32'h0,        8'd9},
        '{OP_LOOK,       32'h00030000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd9},  // R9 way 2 evicted
        '{OP_LOOK,       32'h00040000, 32'h0,        1'b1, 1'b0, 32'h44444001, 32'h0,        8'd2},  // R2
        '{OP_LOOK,       32'h00050007, 32'h0,        1'b1, 1'b0, 32'h55555001, 32'h0,        8'd9},  // R9
        '{OP_LOOK,       32'h00060010, 32'h0,        1'b1, 1'b0, 32'h66666001, 32'h0,        8'd9},  // R9
        '{OP_FILL_L,     32'h00040000, 32'h4444F001, 1'b0, 1'b0, 32'h0,        32'h0,        8'd7},
        '{OP_LOOK,       32'h00040004, 32'h0,        1'b1, 1'b0, 32'h4444F001, 32'h0,        8'd7},  // R7 overwrite
        '{OP_LOOK,       32'h00020001, 32'h0,        1'b1, 1'b0, 32'h22222101, 32'h0,        8'd7},  // R7 neighbour kept
        '{OP_FILL_D,     32'h01400000, 32'h77777003, 1'b0, 1'b0, 32'h0,        32'h0,        8'd5},
        '{OP_LOOK,       32'h017FF123, 32'h0,        1'b0, 1'b1, 32'h0,        32'h77777003, 8'd5},  // R5
        '{OP_LOOK,       32'h00055000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd2},  // R2 flag separates kinds
        '{OP_FILL_L,     32'h00055000, 32'h88888101, 1'b0, 1'b0, 32'h0,        32'h0,        8'd6},
        '{OP_LOOK,       32'h00055ABC, 32'h0,        1'b1, 1'b0, 32'h88888101, 32'h0,        8'd2},  // R2
        '{OP_LOOK,       32'h0140F010, 32'h0,        1'b0, 1'b1, 32'h0,        32'h77777003, 8'd5},  // R5
        '{OP_FLUSH_TASK, 32'h0,        32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd11},
        '{OP_LOOK,       32'h00020000, 32'h0,        1'b1, 1'b0, 32'h22222101, 32'h0,        8'd11}, // R11 global kept
        '{OP_LOOK,       32'h00040000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd11}, // R11 local gone
        '{OP_LOOK,       32'h017FF000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd11}, // R11 directory gone
        '{OP_LOOK,       32'h00055001, 32'h0,        1'b1, 1'b0, 32'h88888101, 32'h0,        8'd11}, // R11
        '{OP_FLUSH_ALL,  32'h0,        32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd10},
        '{OP_LOOK,       32'h00020000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd10}, // R10
        '{OP_LOOK,       32'h00055000, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,        8'd10}  // R10
    };

    task automatic idle_inputs();
        lk_en      = 1'b0;
        fill_en    = 1'b0;
        fill_dir   = 1'b0;
        flush_all  = 1'b0;
        flush_task = 1'b0;
    endtask

    task automatic check_out(input logic e_lh, input logic e_dh, input logic [31:0] e_pte,
                             input logic [31:0] e_pde, input string what);
        logic        e_miss;
        logic [31:0] e_pa;
        e_miss = lk_en && !e_lh;
        e_pa   = e_lh ? {e_pte[31:12], lk_va[11:0]} : 32'h0;
        n_checks++;
        if (lk_hit !== e_lh || lk_miss !== e_miss || lk_dir_hit !== e_dh ||
            lk_pa !== e_pa || lk_pte !== e_pte || lk_dir_pte !== e_pde) begin
            n_errors++;
            $display("FAIL %s: hit=%b miss=%b dir=%b pa=%h pte=%h pde=%h expected hit=%b miss=%b dir=%b pa=%h pte=%h pde=%h",
                     what, lk_hit, lk_miss, lk_dir_hit, lk_pa, lk_pte, lk_dir_pte,
                     e_lh, e_miss, e_dh, e_pa, e_pte, e_pde);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic e_lh, input logic [31:0] e_pte, input string what);
        @(negedge clk);
        idle_inputs();
        lk_en = 1'b1;
        lk_va = va;
        #2;
        check_out(e_lh, 1'b0, e_pte, 32'h0, what);
    endtask

    task automatic fill_leaf(input logic [19:0] vpn, input logic [31:0] data);
        @(negedge clk);
        idle_inputs();
        fill_en  = 1'b1;
        fill_vpn = vpn;
        fill_pte = data;
    endtask

    initial begin
        #(8 * 50000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n    = 1'b0;
        lk_va    = '0;
        fill_vpn = '0;
        fill_pte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            unique case (VECS[i].op)
                OP_LOOK: begin
                    lk_en = 1'b1;
                    lk_va = VECS[i].va;
                    #2;
                    check_out(VECS[i].exp_lh, VECS[i].exp_dh, VECS[i].exp_pte, VECS[i].exp_pde,
                              $sformatf("R%0d vector %0d", VECS[i].req, i));
                end
                OP_FILL_L, OP_FILL_D: begin
                    fill_en  = 1'b1;
                    fill_dir = (VECS[i].op == OP_FILL_D);
                    fill_vpn = VECS[i].va[31:12];
                    fill_pte = VECS[i].data;
                end
                OP_FLUSH_TASK: flush_task = 1'b1;
                OP_FLUSH_ALL:  flush_all  = 1'b1;
            endcase
        end

        // R4: lookup disabled gives no hit and no miss
        fill_leaf(20'h00ABC, 32'h99999001);
        @(negedge clk);
        idle_inputs();
        lk_va = 32'h00ABC000;
        #2;
        check_out(1'b0, 1'b0, 32'h0, 32'h0, "R4 lookup disabled");
        look(32'h00ABC555, 1'b1, 32'h99999001, "R4 lookup enabled");

        // R6: write not visible in its own cycle, visible in the next
        @(negedge clk);
        idle_inputs();
        fill_en  = 1'b1;
        fill_vpn = 20'h00777;
        fill_pte = 32'hABCDE001;
        lk_en    = 1'b1;
        lk_va    = 32'h00777000;
        #2;
        check_out(1'b0, 1'b0, 32'h0, 32'h0, "R6 same-cycle lookup");
        look(32'h00777FFC, 1'b1, 32'hABCDE001, "R6 next-cycle lookup");

        // R12: refill dropped when a flush coincides
        @(negedge clk);
        idle_inputs();
        fill_en   = 1'b1;
        fill_vpn  = 20'h00888;
        fill_pte  = 32'h12345001;
        flush_all = 1'b1;
        look(32'h00888000, 1'b0, 32'h0, "R12 fill with full flush");
        @(negedge clk);
        idle_inputs();
        fill_en    = 1'b1;
        fill_vpn   = 20'h00999;
        fill_pte   = 32'h54321101;
        flush_task = 1'b1;
        look(32'h00999000, 1'b0, 32'h0, "R12 fill with task flush");

        // R1: reset mid-run empties the structure
        fill_leaf(20'h00ABC, 32'h99999001);
        look(32'h00ABC000, 1'b1, 32'h99999001, "R1 entry before reset");
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h00ABC000, 1'b0, 32'h0, "R1 entry after reset");

        @(negedge clk);
        idle_inputs();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule